// File: doc/BRIEF.md
# Two-Mode Pulse Accumulator

This block counts activity on a single external input into an 8-bit counter. In event mode it adds one for each chosen edge of that input. In gated mode it adds one for every 64 system-clock cycles during which the input sits at its active level, so the count measures how long the input was active. Before any edge detection or gating, the input passes through a two-flop synchroniser. The divide-by-64 tick generator is part of the block.

Software configures the block through a small write port with three register slots:
- control (enable, mode, polarity, two interrupt enables),
- the count itself, which can be loaded,
- a flag register cleared by writing ones.

The count, both flags and a combined interrupt request are outputs. A single polarity bit does two jobs, depending on the mode. In event mode it picks the counted edge. In gated mode it picks the active level.

Top module: `pulse_accum_top`

## Requirements
- R1: While reset is asserted and after its release, `count_o` is 0, `flags_o` is 0, `irq_o` is 0 and every control bit is 0.
- R2: While the enable bit (control bit 0) is 0, the count does not change except by a count write, and neither flag sets.
- R3: With mode bit (control bit 1) at 0, the count adds one on each selected input edge. Polarity bit (control bit 2) 0 selects falling edges and 1 selects rising edges.
- R4: With mode bit 1, the count adds one on each tick of a free-running divide-by-64 of the clock, but only while the input is at its active level. Polarity 0 means active high and polarity 1 means active low.
- R5: The edge flag (`flags_o[1]`) sets on the edge that polarity selects. In gated mode that is the edge ending an active period: falling for polarity 0, rising for polarity 1.
- R6: An increment at count 0xFF wraps the count to 0x00 and sets the overflow flag (`flags_o[0]`).
- R7: A write to slot 2 clears each flag whose data bit is 1 (bit 0 overflow, bit 1 edge). Zero bits have no effect. A flag set in the same cycle as its clear stays set.
- R8: A write to slot 1 loads the count from the data. The load wins over a same-cycle increment, and in that case no overflow is flagged.
- R9: `irq_o` is 1 exactly when the overflow flag is set with control bit 3 set, or the edge flag is set with control bit 4 set.
- R10: An input change is counted on the third rising clock edge after it is sampled: two synchroniser flops, then the counter register.
- R11: A write to slot 3 changes nothing. Slot 0 loads control bits 4:0 from data bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 1 | External input being counted or gating time |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Slot: 0 control, 1 count, 2 flag clear, 3 unused |
| reg_wdata | input | 8 | Write data |
| count_o | output | 8 | Current count |
| flags_o | output | 2 | Bit 0 overflow, bit 1 input edge |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A corrupted synchroniser or edge-history flop appears at `count_o` as a missed or extra increment three clock edges after the input moves. A bad divider phase in gated mode shows up within 64 cycles as ticks out of step. A wrong count value becomes visible at once, and it also shows as an overflow flag at the wrong wrap. Flag faults reach `irq_o` in the same cycle, so the bench compares all outputs every cycle against a cycle-level model.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int CTRL_W = 5;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_FLAGS = 2'd2,
    SEL_NONE  = 2'd3
  } pa_sel_e;

  typedef struct packed {
    logic edge_ie;
    logic ovf_ie;
    logic pol;
    logic gated;
    logic en;
  } pa_ctrl_t;

  localparam int FLAG_OVF  = 0;
  localparam int FLAG_EDGE = 1;
endpackage

// File: rtl/pa_input_cond.sv
module pa_input_cond #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;

  for (genvar i = 0; i < SYNC_N; i++) begin : g_stage
    logic d;
    if (i == 0) begin : g_first
      assign d = pin_i;
    end else begin : g_chain
      assign d = sync_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b0;
      else         sync_q[i] <= d;
    end
  end

  assign level_o = sync_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_o;
  end

  assign rise_o = level_o & ~prev_q;
  assign fall_o = ~level_o & prev_q;
endmodule

// File: rtl/pa_tick_gen.sv
module pa_tick_gen #(
  parameter int DIV_W = 6
) (
  input  logic clk,
  input  logic rst_ni,
  output logic tick_o
);
  logic [DIV_W-1:0] div_q, div_d;

  always_comb div_d = div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  assign tick_o = &div_q;
endmodule

// File: rtl/pa_count_core.sv
module pa_count_core #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] count_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;

  always_comb begin
    cnt_ce = load_i | inc_i;
    cnt_d  = load_i ? load_val_i : cnt_q + 1'b1;
    wrap_o = inc_i & ~load_i & (&cnt_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/pa_flag_unit.sv
module pa_flag_unit #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic [NF-1:0] ie_i,
  output logic [NF-1:0] flags_o,
  output logic          irq_o
);
  logic [NF-1:0] flg_q, flg_d;

  always_comb flg_d = set_i | (flg_q & ~clr_i);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= flg_d;
  end

  assign flags_o = flg_q;
  assign irq_o   = |(flg_q & ie_i);
endmodule

// File: rtl/pulse_accum_top.sv
module pulse_accum_top
  import pa_pkg::*;
#(
  parameter int CW     = 8,
  parameter int DIV_W  = 6,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_i,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] count_o,
  output logic [1:0]    flags_o,
  output logic          irq_o
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  pa_ctrl_t ctrl_q, ctrl_d;
  logic     ctrl_ce;

  always_comb begin
    ctrl_ce = reg_wr && (reg_sel == SEL_CTRL);
    ctrl_d  = pa_ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   ctrl_q <= '0;
    else if (ctrl_ce) ctrl_q <= ctrl_d;
  end

  logic level, rise, fall, tick;

  pa_input_cond #(.SYNC_N(SYNC_N)) u_in (
    .clk(clk), .rst_ni(rst_int_n), .pin_i(pin_i),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  pa_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_ni(rst_int_n), .tick_o(tick)
  );

  logic       sel_edge, gate_on, inc, edge_ev, cnt_load, wrap;
  logic [1:0] flag_set, flag_clr, flag_ie;

  always_comb begin
    sel_edge = ctrl_q.pol ? rise : fall;
    gate_on  = level ^ ctrl_q.pol;
    inc      = ctrl_q.en & (ctrl_q.gated ? (gate_on & tick) : sel_edge);
    edge_ev  = ctrl_q.en & sel_edge;
    cnt_load = reg_wr && (reg_sel == SEL_COUNT);
    flag_clr = (reg_wr && (reg_sel == SEL_FLAGS)) ? reg_wdata[1:0] : 2'b00;
    flag_set = '0;
    flag_set[FLAG_OVF]  = wrap;
    flag_set[FLAG_EDGE] = edge_ev;
    flag_ie  = '0;
    flag_ie[FLAG_OVF]   = ctrl_q.ovf_ie;
    flag_ie[FLAG_EDGE]  = ctrl_q.edge_ie;
  end

  pa_count_core #(.CW(CW)) u_cnt (
    .clk(clk), .rst_ni(rst_int_n), .inc_i(inc), .load_i(cnt_load),
    .load_val_i(reg_wdata), .count_o(count_o), .wrap_o(wrap)
  );

  pa_flag_unit #(.NF(2)) u_flg (
    .clk(clk), .rst_ni(rst_int_n), .set_i(flag_set), .clr_i(flag_clr),
    .ie_i(flag_ie), .flags_o(flags_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          reg_wr,
  input logic [1:0]    reg_sel,
  input logic [CW-1:0] reg_wdata,
  input logic [CW-1:0] count_o,
  input logic [1:0]    flags_o,
  input logic          en,
  input logic          gated,
  input logic          tick
);
  logic cnt_wr;
  assign cnt_wr = reg_wr && (reg_sel == 2'd1);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (!en && !cnt_wr) |=> $stable(count_o)); // R2

  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    (!en && flags_o == 2'b00) |=> flags_o == 2'b00); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_ni)
    (!cnt_wr) |=> (count_o == $past(count_o) || count_o == CW'($past(count_o) + 1'b1))); // R3

  AST_GATED_PACE: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && gated && !tick && !cnt_wr) |=> $stable(count_o)); // R4

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(flags_o[0]) |-> ($past(count_o) == {CW{1'b1}} && count_o == '0)); // R6

  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_wr && reg_sel == 2'd2 && reg_wdata[0] && count_o != {CW{1'b1}}) |=> !flags_o[0]); // R7

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_wr |=> count_o == $past(reg_wdata)); // R8
endmodule

bind pulse_accum_top pa_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_ni(rst_int_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .count_o(count_o), .flags_o(flags_o),
  .en(ctrl_q.en), .gated(ctrl_q.gated), .tick(tick)
);

// File: tb/tb_pulse_accum_top.sv
`timescale 1ns/1ps
module tb_pulse_accum_top;
  logic       clk = 1'b0, rst_n = 1'b0, pin = 1'b0, wr = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wd = 8'd0;
  logic [7:0] count;
  logic [1:0] flags;
  logic       irq;

  pulse_accum_top dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .reg_wr(wr), .reg_sel(sel),
    .reg_wdata(wd), .count_o(count), .flags_o(flags), .irq_o(irq)
  );

  always #2 clk = ~clk;

  int  n_chk = 0, n_bad = 0;
  bit  cmp_on = 1'b0, done = 1'b0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-level reference built from the requirements
  logic       m_rs1 = 0, m_rs2 = 0, m_ff1 = 0, m_s = 0, m_p = 0;
  logic [5:0] m_div = 0;
  logic [7:0] m_cnt = 0;
  logic [1:0] m_flg = 0;
  logic [4:0] m_ctl = 0;

  function automatic logic model_irq(logic [1:0] f, logic [4:0] c);
    return (f[0] & c[3]) | (f[1] & c[4]);
  endfunction

  always @(posedge clk) begin
    logic rise, fall, sedge, gate, tick, inc, edg, ld, wrap;
    logic [1:0] clr;
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_ff1 = 0; m_s = 0; m_p = 0;
      m_div = 0; m_cnt = 0; m_flg = 0; m_ctl = 0;
    end else begin
      if (m_rs2) begin
        rise  = m_s & ~m_p;
        fall  = ~m_s & m_p;
        sedge = m_ctl[2] ? rise : fall;
        gate  = m_s ^ m_ctl[2];
        tick  = (m_div == 6'd63);
        inc   = m_ctl[0] & (m_ctl[1] ? (gate & tick) : sedge);
        edg   = m_ctl[0] & sedge;
        ld    = wr && sel == 2'd1;
        wrap  = inc && !ld && m_cnt == 8'hFF;
        clr   = (wr && sel == 2'd2) ? wd[1:0] : 2'b00;
        if (ld) m_cnt = wd;
        else if (inc) m_cnt = m_cnt + 8'd1;
        m_flg = {edg, wrap} | (m_flg & ~clr);
        if (wr && sel == 2'd0) m_ctl = wd[4:0];
        m_p = m_s; m_s = m_ff1; m_ff1 = pin;
        m_div = m_div + 6'd1;
      end
      m_rs2 = m_rs1; m_rs1 = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R10 count vs model", count, m_cnt);
      chk("R7 flags vs model", flags, m_flg);
      chk("R9 irq vs model", irq, model_irq(m_flg, m_ctl));
    end
  end

  task automatic wreg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; sel = s; wd = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic setpin(input logic v);
    @(negedge clk); pin = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk("R1 count in reset", count, 0);
    chk("R1 flags in reset", flags, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp_on = 1'b1;
    chk("R1 count after reset", count, 0);
    chk("R1 irq after reset", irq, 0);

    setpin(1); setpin(0); setpin(1); setpin(0);
    chk("R2 disabled count", count, 0);
    chk("R2 disabled flags", flags, 0);

    wreg(2'd0, 8'h01);
    for (int i = 0; i < 3; i++) begin setpin(1); setpin(0); end
    chk("R3 falling edges counted", count, 3);
    chk("R5 edge flag event", flags, 2'b10);
    wreg(2'd2, 8'h00);
    chk("R7 zero write keeps flag", flags, 2'b10);
    wreg(2'd2, 8'h02);
    chk("R7 clear edge flag", flags, 2'b00);

    wreg(2'd0, 8'h05); wreg(2'd1, 8'h00);
    setpin(1); setpin(0); setpin(1); setpin(0);
    chk("R3 rising edges counted", count, 2);

    wreg(2'd2, 8'h03); wreg(2'd1, 8'hFE); wreg(2'd0, 8'h0D);
    setpin(1); setpin(0); setpin(1); setpin(0);
    chk("R6 wrap to zero", count, 0);
    chk("R6 overflow flag", flags[0], 1);
    chk("R9 irq on overflow", irq, 1);

    wreg(2'd3, 8'hFF);
    chk("R11 slot 3 count", count, 0);
    chk("R11 slot 3 flags", flags, 2'b11);

    // R8: load in the cycle a falling edge increments
    wreg(2'd2, 8'h03); wreg(2'd0, 8'h01);
    setpin(1);
    @(negedge clk); pin = 1'b0;
    @(negedge clk);
    @(negedge clk); wr = 1'b1; sel = 2'd1; wd = 8'h40;
    @(negedge clk); wr = 1'b0;
    chk("R8 load beats increment", count, 8'h40);
    repeat (3) @(negedge clk);
    chk("R8 increment dropped", count, 8'h40);

    wreg(2'd2, 8'h03); wreg(2'd1, 8'h00); wreg(2'd0, 8'h03);
    setpin(1);
    repeat (320) @(negedge clk);
    chk("R4 gated time accumulates", (count >= 4 && count <= 6) ? 1 : 0, 1);
    setpin(0);
    chk("R5 edge flag at gate end", flags[1], 1);
    begin
      logic [7:0] held;
      held = count;
      repeat (200) @(negedge clk);
      chk("R4 inactive gate holds", count, held);
    end
    wreg(2'd0, 8'h17);
    repeat (200) @(negedge clk);
    chk("R4 active-low gate counts", (count != 0) ? 1 : 0, 1);

    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      wr = 1'b0;
      if ($urandom_range(0, 7) == 0) pin = ~pin;
      if ($urandom_range(0, 11) == 0) begin
        wr  = 1'b1;
        sel = 2'($urandom_range(0, 3));
        wd  = 8'($urandom);
        if (sel == 2'd0) wd[0] = ($urandom_range(0, 4) != 0);
        if (sel == 2'd1 && $urandom_range(0, 1) == 0) wd = 8'hFD;
      end
    end
    @(negedge clk); wr = 1'b0;
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule